// File: doc/BRIEF.md
# Coprocessor Sleep Wake-Up Timer

This block decides when a low-power coprocessor is allowed to run. While software holds the enable high, a down-counter is decremented on each slow-clock tick. The tick arrives as a single-cycle enable on the fast clock. The counter is loaded from one of five programmable 32-bit sleep-period registers. When it runs out, the block raises a one-cycle start pulse, latches the program start address from the initial-PC input, and holds a run level high. The coprocessor then runs until it reports a halt. The halt re-arms the counter with a fresh period, and the loop repeats.

A sleep instruction executed by the coprocessor changes which period register is used from the next reload onward. After reset the selection is index 0, so the first run comes only once period register 0 has expired. Clearing the enable stops all further wake-ups. A run already in progress still ends normally with its halt.

Top module: `cp_wake_timer`

## Requirements
- R1: With `timer_en` low, no start pulse is produced. Clearing `timer_en` while counting returns the block to the disabled state and discards the countdown.
- R2: The countdown advances only on cycles where `tick_en` is high. Every start pulse coincides with the cycle after an edge that saw `tick_en` high.
- R3: `start_o` is high for exactly one cycle per expiry, and `run_o` is high in that cycle. Both are low after reset.
- R4: On expiry, `pc_o` takes the value `pc_init_i` had at the expiring edge and holds it until the next expiry. It is 0 after reset.
- R5: While `run_o` is high the counter does not advance, and no further start pulse occurs.
- R6: A `halt_i` seen while running clears `run_o` in the following cycle. If `timer_en` is high, the halt reloads the counter from the selected period register.
- R7: After reset the selection is index 0, and every period register resets to the parameter `RST_PERIOD`. A period of P expires on the (P+1)-th tick after the arming edge, which is either the enable edge or the halt edge.
- R8: A `sleep_vld` pulse stores `sleep_sel` as the new selection. The new selection applies to the next reload, including a reload in the same cycle.
- R9: A `sleep_sel` above 4 is stored as 4.
- R10: A period value of 0 expires on the first tick after arming.
- R11: A period write (`period_wr_en`) to indices 0 to 4 replaces that register, and the new value is used at the next reload. A write to an index of 5 or more changes nothing.
- R12: A halt that arrives while `timer_en` is low leaves the block disabled. No start follows until the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow-clock tick, one cycle wide |
| timer_en | input | 1 | Software enable for the wake-up mechanism |
| period_wr_en | input | 1 | Write strobe for a period register |
| period_wr_idx | input | 3 | Period register index to write |
| period_wr_data | input | 32 | Period value to write |
| pc_init_i | input | 11 | Program start address used on wake-up |
| sleep_vld | input | 1 | Sleep instruction strobe |
| sleep_sel | input | 3 | Period index requested by the sleep instruction |
| halt_i | input | 1 | Halt indication from the coprocessor |
| start_o | output | 1 | One-cycle start request |
| run_o | output | 1 | Coprocessor run level |
| pc_o | output | 11 | Latched start program counter |

## Verification
All three outputs are registered. `start_o`, `run_o` and `pc_o` change at the edge that consumes the expiring tick, and `run_o` falls at the edge that samples the halt. A reload therefore shows up as P+1 ticks counted from the arming edge.

The bench drives inputs just after the falling edge and compares every output against a behavioural model at the next falling edge. This places each check one register stage after the stimulus edge. Directed checks count ticks between the arming edge and the observed start. They also confirm `run_o` in the cycle right after a halt.

// File: rtl/cpwt_pkg.sv
package cpwt_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } cpwt_state_e;
endpackage

// File: rtl/cpwt_rst_sync.sv
module cpwt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cpwt_period_bank.sv
module cpwt_period_bank #(
  parameter int          NUM     = 5,
  parameter int          W       = 32,
  parameter int          SEL_W   = 3,
  parameter logic [31:0] RST_VAL = 32'd100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] per_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_per
    logic         hit;
    logic [W-1:0] q;

    assign hit = wr_en && (wr_idx == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= W'(RST_VAL);
      else if (hit) q <= wr_data;
    end

    assign per_q[g] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_idx == SEL_W'(i)) rd_data = per_q[i];
    end
  end
endmodule

// File: rtl/cpwt_sel_reg.sv
module cpwt_sel_reg #(
  parameter int NUM   = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_vld,
  input  logic [SEL_W-1:0] sleep_sel,
  output logic [SEL_W-1:0] sel_nxt
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM - 1);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] req_clamped;

  always_comb begin
    req_clamped = (sleep_sel > LAST) ? LAST : sleep_sel;
    sel_nxt     = sleep_vld ? req_clamped : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_nxt;
  end
endmodule

// File: rtl/cpwt_countdown.sv
module cpwt_countdown #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         cnt_zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || dec;
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/cpwt_fsm.sv
module cpwt_fsm
  import cpwt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        timer_en,
  input  logic        tick,
  input  logic        cnt_zero,
  input  logic        halt,
  output cpwt_state_e state_q,
  output logic        load,
  output logic        dec,
  output logic        expire
);
  cpwt_state_e state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    dec     = 1'b0;
    expire  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (timer_en) begin
          state_d = ST_COUNT;
          load    = 1'b1;
        end
      end
      ST_COUNT: begin
        if (!timer_en) begin
          state_d = ST_OFF;
        end else if (tick) begin
          if (cnt_zero) begin
            state_d = ST_RUN;
            expire  = 1'b1;
          end else begin
            dec = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (halt) begin
          if (timer_en) begin
            state_d = ST_COUNT;
            load    = 1'b1;
          end else begin
            state_d = ST_OFF;
          end
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/cp_wake_timer.sv
module cp_wake_timer
  import cpwt_pkg::*;
#(
  parameter int          NUM_PER    = 5,
  parameter int          PER_W      = 32,
  parameter int          SEL_W      = 3,
  parameter int          PC_W       = 11,
  parameter logic [31:0] RST_PERIOD = 32'd100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             timer_en,
  input  logic             period_wr_en,
  input  logic [SEL_W-1:0] period_wr_idx,
  input  logic [PER_W-1:0] period_wr_data,
  input  logic [PC_W-1:0]  pc_init_i,
  input  logic             sleep_vld,
  input  logic [SEL_W-1:0] sleep_sel,
  input  logic             halt_i,
  output logic             start_o,
  output logic             run_o,
  output logic [PC_W-1:0]  pc_o
);
  logic             rst_n_int;
  logic [SEL_W-1:0] sel_nxt;
  logic [PER_W-1:0] per_val;
  logic             cnt_zero;
  logic             load;
  logic             dec;
  logic             expire;
  cpwt_state_e      state_q;
  logic             start_q;
  logic [PC_W-1:0]  pc_q;

  cpwt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cpwt_sel_reg #(.NUM(NUM_PER), .SEL_W(SEL_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sleep_vld (sleep_vld),
    .sleep_sel (sleep_sel),
    .sel_nxt   (sel_nxt)
  );

  cpwt_period_bank #(
    .NUM(NUM_PER), .W(PER_W), .SEL_W(SEL_W), .RST_VAL(RST_PERIOD)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (period_wr_en),
    .wr_idx  (period_wr_idx),
    .wr_data (period_wr_data),
    .rd_idx  (sel_nxt),
    .rd_data (per_val)
  );

  cpwt_countdown #(.W(PER_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (load),
    .load_val (per_val),
    .dec      (dec),
    .cnt_zero (cnt_zero)
  );

  cpwt_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .timer_en (timer_en),
    .tick     (tick_en),
    .cnt_zero (cnt_zero),
    .halt     (halt_i),
    .state_q  (state_q),
    .load     (load),
    .dec      (dec),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) start_q <= 1'b0;
    else            start_q <= expire;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  pc_q <= '0;
    else if (expire) pc_q <= pc_init_i;
  end

  assign start_o = start_q;
  assign run_o   = (state_q == ST_RUN);
  assign pc_o    = pc_q;
endmodule

// File: rtl/cpwt_checker.sv
module cpwt_checker #(
  parameter int PC_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_en,
  input logic            timer_en,
  input logic            halt_i,
  input logic [PC_W-1:0] pc_init_i,
  input logic            start_o,
  input logic            run_o,
  input logic [PC_W-1:0] pc_o
);
  a_r1_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(timer_en));

  a_r2_start_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(tick_en));

  a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  a_r3_start_with_run: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> run_o);

  a_r4_pc_captured: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (pc_o == $past(pc_init_i)));

  a_r4_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |=> (start_o || $stable(pc_o)));

  a_r5_no_restart_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(run_o));

  a_r6_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && halt_i) |=> !run_o);
endmodule

bind cp_wake_timer cpwt_checker #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .timer_en  (timer_en),
  .halt_i    (halt_i),
  .pc_init_i (pc_init_i),
  .start_o   (start_o),
  .run_o     (run_o),
  .pc_o      (pc_o)
);

// File: tb/cp_wake_timer_bench.sv
`timescale 1ns/1ps
module cp_wake_timer_bench;
  localparam int P0 = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        timer_en = 1'b0;
  logic        period_wr_en = 1'b0;
  logic [2:0]  period_wr_idx = '0;
  logic [31:0] period_wr_data = '0;
  logic [10:0] pc_init_i = '0;
  logic        sleep_vld = 1'b0;
  logic [2:0]  sleep_sel = '0;
  logic        halt_i = 1'b0;
  logic        start_o;
  logic        run_o;
  logic [10:0] pc_o;

  always #10 clk = ~clk;

  cp_wake_timer #(.RST_PERIOD(32'(P0))) u_cp_wake_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .timer_en(timer_en),
    .period_wr_en(period_wr_en), .period_wr_idx(period_wr_idx),
    .period_wr_data(period_wr_data), .pc_init_i(pc_init_i),
    .sleep_vld(sleep_vld), .sleep_sel(sleep_sel), .halt_i(halt_i),
    .start_o(start_o), .run_o(run_o), .pc_o(pc_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;
  int tick_div = 1;
  longint tick_cnt = 0;
  int start_cnt = 0;
  bit done = 1'b0;

  // behavioural reference: 0 off, 1 counting, 2 running
  int     m_st = 0;
  longint m_cnt = 0;
  int     m_sel = 0;
  longint m_per [5];
  bit     m_start = 1'b0;
  int     m_pc = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sel = 0; m_start = 0; m_pc = 0;
      foreach (m_per[i]) m_per[i] = P0;
    end else begin
      int new_sel;
      new_sel = sleep_vld ? ((sleep_sel > 4) ? 4 : int'(sleep_sel)) : m_sel;
      m_start = 0;
      if (m_st == 0) begin
        if (timer_en) begin m_st = 1; m_cnt = m_per[new_sel]; end
      end else if (m_st == 1) begin
        if (!timer_en) m_st = 0;
        else if (tick_en) begin
          if (m_cnt == 0) begin m_st = 2; m_start = 1; m_pc = int'(pc_init_i); end
          else m_cnt--;
        end
      end else begin
        if (halt_i) begin
          if (timer_en) begin m_st = 1; m_cnt = m_per[new_sel]; end
          else m_st = 0;
        end
      end
      if (period_wr_en && period_wr_idx < 5) m_per[period_wr_idx] = longint'(period_wr_data);
      m_sel = new_sel;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && tick_en) tick_cnt++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_o) start_cnt++;
      chk(start_o == m_start, "R3 start_o vs model", start_o, m_start);
      chk(run_o == (m_st == 2), "R5 run_o vs model", run_o, (m_st == 2));
      chk(int'(pc_o) == m_pc, "R4 pc_o vs model", pc_o, m_pc);
    end
    #1 tick_en = rst_n && ((cyc % tick_div) == 0);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic write_per(int idx, longint val);
    @(negedge clk); #2;
    period_wr_en = 1; period_wr_idx = 3'(idx); period_wr_data = 32'(val);
    @(negedge clk); #2;
    period_wr_en = 0;
  endtask

  task automatic pulse_sleep(int sel);
    @(negedge clk); #2;
    sleep_vld = 1; sleep_sel = 3'(sel);
    @(negedge clk); #2;
    sleep_vld = 0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); #2;
    halt_i = 1;
    @(negedge clk); #2;
    halt_i = 0;
  endtask

  // called right after the arming edge: counts ticks until start_o
  task automatic measure(longint exp_ticks, string tag);
    longint t0;
    bit seen;
    t0 = tick_cnt;
    seen = 0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      @(negedge clk);
      if (start_o) seen = 1;
    end
    chk(seen, {tag, " start seen"}, seen, 1);
    chk(tick_cnt - t0 == exp_ticks, {tag, " ticks to expiry"}, tick_cnt - t0, exp_ticks);
    #2;
  endtask

  initial begin
    int sc;
    rst_n = 0;
    idle(3);
    chk(start_o == 0, "R3 reset start_o", start_o, 0);
    chk(run_o == 0, "R3 reset run_o", run_o, 0);
    chk(pc_o == 0, "R4 reset pc_o", pc_o, 0);
    rst_n = 1;
    idle(20);
    chk(start_cnt == 0, "R1 no start while disabled", start_cnt, 0);

    // first arm: period register 0 at its reset value
    pc_init_i = 11'h155;
    @(negedge clk); #2; timer_en = 1;
    @(negedge clk); #2;
    measure(P0 + 1, "R7");
    chk(pc_o == 11'h155, "R4 pc loaded", pc_o, 11'h155);
    chk(run_o == 1, "R3 run with start", run_o, 1);
    pc_init_i = 11'h2AA;
    idle(10);
    chk(start_cnt == 1, "R5 no count while running", start_cnt, 1);
    chk(pc_o == 11'h155, "R4 pc held", pc_o, 11'h155);

    // zero period via sleep select 2
    write_per(2, 0);
    pulse_sleep(2);
    pulse_halt();
    chk(run_o == 0, "R6 run cleared after halt", run_o, 0);
    measure(1, "R10 R8");
    chk(pc_o == 11'h2AA, "R4 new pc", pc_o, 11'h2AA);

    // select above range clamps to 4
    write_per(4, 6);
    pulse_sleep(7);
    pulse_halt();
    measure(7, "R9");

    // write to a nonexistent index changes nothing
    write_per(5, 0);
    pulse_halt();
    measure(7, "R11");

    // sparse ticks
    write_per(1, 2);
    pulse_sleep(1);
    tick_div = 3;
    pulse_halt();
    measure(3, "R2");
    tick_div = 1;

    // halt with enable low stays disabled
    @(negedge clk); #2; timer_en = 0;
    pulse_halt();
    sc = start_cnt;
    idle(30);
    chk(run_o == 0, "R12 run low after halt", run_o, 0);
    chk(start_cnt == sc, "R12 no wake-up", start_cnt, sc);

    // disable in mid-count discards the countdown
    @(negedge clk); #2; timer_en = 1;
    @(negedge clk); #2; timer_en = 0;
    sc = start_cnt;
    idle(30);
    chk(start_cnt == sc, "R1 disabled mid-count", start_cnt, sc);

    // re-enable: full period from register 1 again
    @(negedge clk); #2; timer_en = 1;
    @(negedge clk); #2;
    measure(3, "R1 rearm");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule